// File: doc/BRIEF.md
# Shared-Port Indexed Register Bank

This block holds a bank of byte-wide registers that a host reaches through a single write strobe. Successive writes to that strobe alternate between selecting a register and loading it. An internal phase bit tells the two apart. Software returns the phase to "select" by reading an input-status byte, and that byte answers at one of two addresses (monochrome or colour), chosen by an address-select input.

Separate read strobes return the selected register's contents or the current selection. All accesses are single bytes, and the read result is combinational on the cycle the strobe is asserted.

The selection register can hold one value past the last register: a null slot. Data written there is discarded, and reads from it return zero. Selection values beyond the null slot are refused, but they still move the phase on, so that the host's next byte is still taken as data.

Top module: `shared_port_regbank`

## Requirements
- R1: After reset every register reads 0, the selection reads 0 and the next combined-port write is taken as a selection.
- R2: In select phase, a combined-port write of a value 0..21 loads that value as the selection and moves to data phase.
- R3: In data phase, a combined-port write stores the byte in the selected register, leaves the selection unchanged and returns to select phase.
- R4: In select phase, a combined-port write of a value above 21 leaves the selection unchanged, yet the phase still moves to data phase.
- R5: A data-port read returns the selected register, or 0 when the selection is 21 (the null slot).
- R6: A selection-port read returns the selection zero-extended to 8 bits and does not change the phase.
- R7: A status strobe at the active address (mono strobe when color_sel=0, colour strobe when color_sel=1) returns stat_val and forces select phase.
- R8: A status strobe at the inactive address returns 0 and leaves the phase unchanged.
- R9: When a combined-port write and an active status read share a cycle, the write acts as its phase dictates and the phase afterwards is select.
- R10: With no read strobe rd_byte is 0; with several strobes the priority is data port, then selection port, then status.
- R11: A data-phase write while the selection is 21 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_combo | input | 1 | Write strobe of the shared selection/data port |
| wr_byte | input | 8 | Write data |
| rd_data_cs | input | 1 | Read strobe of the data port |
| rd_idx_cs | input | 1 | Read strobe of the selection port |
| stat_mono_cs | input | 1 | Status read strobe at the monochrome address |
| stat_color_cs | input | 1 | Status read strobe at the colour address |
| color_sel | input | 1 | Address select: 1 makes the colour address active |
| stat_val | input | 8 | Value presented by a status read |
| rd_byte | output | 8 | Read data |

## Verification
The bench targets the phase bit. It reads the status byte halfway through a pair, so a design that ignored the clear would load the following selection into a register. It also reads the selection between the two halves of a pair, which catches a design that toggled on that read. Refused selections are followed by a data byte: a design that refused without advancing the phase, or that stored the truncated value, would write the wrong register. Null-slot writes, status strobes at the inactive address and a write on the same cycle as a status read each show up as a wrong register value or a shifted phase on later reads.

// File: rtl/shared_port_regbank.sv
module shared_port_regbank #(
  parameter int NREGS = 21,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_combo,
  input  logic [DW-1:0] wr_byte,
  input  logic          rd_data_cs,
  input  logic          rd_idx_cs,
  input  logic          stat_mono_cs,
  input  logic          stat_color_cs,
  input  logic          color_sel,
  input  logic [DW-1:0] stat_val,
  output logic [DW-1:0] rd_byte
);
  localparam int IW = $clog2(NREGS + 1);
  localparam logic [DW-1:0] IDX_LIMIT = DW'(NREGS);

  logic          data_phase_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] bank_q [NREGS];
  logic [DW-1:0] sel_val;

  wire stat_hit = color_sel ? stat_color_cs : stat_mono_cs;
  wire idx_ok   = wr_byte <= IDX_LIMIT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_phase_q <= 1'b0;
      idx_q        <= '0;
    end else begin
      if (wr_combo && !data_phase_q && idx_ok) idx_q <= wr_byte[IW-1:0];
      if (stat_hit)      data_phase_q <= 1'b0;
      else if (wr_combo) data_phase_q <= !data_phase_q;
    end
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) bank_q[g] <= '0;
      else if (wr_combo && data_phase_q && idx_q == IW'(g)) bank_q[g] <= wr_byte;
    end
  end

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NREGS; i++)
      if (idx_q == IW'(i)) sel_val = bank_q[i];
  end

  always_comb begin
    if (rd_data_cs)     rd_byte = sel_val;
    else if (rd_idx_cs) rd_byte = DW'(idx_q);
    else if (stat_hit)  rd_byte = stat_val;
    else                rd_byte = '0;
  end
endmodule

// File: rtl/shared_port_regbank_chk.sv
module shared_port_regbank_chk #(
  parameter int NREGS = 21,
  parameter int DW    = 8,
  parameter int IW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_combo,
  input logic [DW-1:0] wr_byte,
  input logic          rd_idx_cs,
  input logic          stat_mono_cs,
  input logic          stat_color_cs,
  input logic          color_sel,
  input logic          phase,
  input logic [IW-1:0] idx
);
  logic hit;
  assign hit = color_sel ? stat_color_cs : stat_mono_cs;

  p_index_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_combo && !phase && wr_byte <= DW'(NREGS) && !hit) |=> (phase && idx == $past(wr_byte[IW-1:0])));

  p_data_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_combo && phase) |=> (!phase && $stable(idx)));

  p_bad_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_combo && !phase && wr_byte > DW'(NREGS) && !hit) |=> (phase && $stable(idx)));

  p_idx_read_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_cs && !wr_combo && !hit) |=> $stable(phase));

  p_status_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !phase);

  p_inactive_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_combo && !hit) |=> $stable(phase));
endmodule

bind shared_port_regbank shared_port_regbank_chk #(.NREGS(NREGS), .DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_combo(wr_combo), .wr_byte(wr_byte),
  .rd_idx_cs(rd_idx_cs), .stat_mono_cs(stat_mono_cs), .stat_color_cs(stat_color_cs),
  .color_sel(color_sel), .phase(data_phase_q), .idx(idx_q)
);

// File: tb/shared_port_regbank_test.sv
module shared_port_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_combo = 0, rd_data_cs = 0, rd_idx_cs = 0;
  logic stat_mono_cs = 0, stat_color_cs = 0, color_sel = 0;
  logic [7:0] wr_byte = 0, stat_val = 0;
  logic [7:0] rd_byte;

  int checks = 0, fails = 0;
  int mreg [N];
  int midx = 0;
  bit mphase = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_port_regbank uut (
    .clk(clk), .rst_n(rst_n), .wr_combo(wr_combo), .wr_byte(wr_byte),
    .rd_data_cs(rd_data_cs), .rd_idx_cs(rd_idx_cs), .stat_mono_cs(stat_mono_cs),
    .stat_color_cs(stat_color_cs), .color_sel(color_sel), .stat_val(stat_val),
    .rd_byte(rd_byte)
  );

  task automatic op(input bit w, input int wd, input bit rdd, input bit rdi,
                    input bit sm, input bit sc, input bit cs, input int sv, input string req);
    int exp;
    bit hit;
    @(negedge clk);
    wr_combo = w; wr_byte = 8'(wd); rd_data_cs = rdd; rd_idx_cs = rdi;
    stat_mono_cs = sm; stat_color_cs = sc; color_sel = cs; stat_val = 8'(sv);
    #1;
    hit = cs ? sc : sm;
    if (rdd)      exp = (midx < N) ? mreg[midx] : 0;
    else if (rdi) exp = midx;
    else if (hit) exp = sv;
    else          exp = 0;
    checks++;
    if (rd_byte !== 8'(exp)) begin
      fails++;
      $display("FAIL %s: rd_byte=%0h expected=%0h", req, rd_byte, exp);
    end
    if (w) begin
      if (!mphase) begin
        if (wd <= N) midx = wd;
        mphase = 1;
      end else begin
        if (midx < N) mreg[midx] = wd;
        mphase = 0;
      end
    end
    if (hit) mphase = 0;
  endtask

  task automatic idle(input string req);
    op(0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic wr(input int v, input string req);
    op(1, v, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic rdat(input string req);
    op(0, 0, 1, 0, 0, 0, 0, 0, req);
  endtask
  task automatic ridx(input string req);
    op(0, 0, 0, 1, 0, 0, 0, 0, req);
  endtask
  task automatic clr();
    op(0, 0, 0, 0, 1, 0, 0, 8'h5A, "R7");
  endtask

  initial begin
    for (int i = 0; i < N; i++) mreg[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    ridx("R1"); rdat("R1"); idle("R10");
    wr(7, "R1"); rdat("R1"); clr();

    wr(5, "R2"); ridx("R6"); ridx("R6"); wr(8'hA5, "R3"); rdat("R3"); ridx("R3");

    for (int i = 0; i < N; i++) begin wr(i, "R2"); wr(i * 11 + 3, "R3"); end
    for (int i = 0; i < N; i++) begin wr(i, "R2"); rdat("R5"); clr(); end

    wr(9, "R2"); wr(8'h11, "R3");
    wr(200, "R4"); ridx("R4"); wr(8'h77, "R4"); rdat("R4");
    wr(22, "R4"); wr(8'h66, "R4"); rdat("R4");

    wr(21, "R2"); rdat("R5"); wr(8'h55, "R11"); rdat("R11"); ridx("R11");
    for (int i = 0; i < N; i++) begin wr(i, "R11"); rdat("R11"); clr(); end

    wr(3, "R7"); op(0, 0, 0, 0, 0, 1, 1, 8'hC3, "R7"); wr(4, "R7"); wr(8'h44, "R7"); rdat("R7");
    wr(6, "R8"); op(0, 0, 0, 0, 0, 1, 0, 8'h99, "R8"); op(0, 0, 0, 0, 1, 0, 1, 8'h98, "R8");
    wr(8'h66, "R8"); rdat("R8");
    wr(2, "R7"); op(0, 0, 0, 0, 1, 0, 0, 8'h3C, "R7"); wr(8, "R7"); wr(8'h88, "R7"); rdat("R7");

    op(1, 10, 0, 0, 0, 1, 1, 8'h12, "R9"); ridx("R9"); wr(11, "R9"); wr(8'hBB, "R9"); rdat("R9");
    wr(12, "R9"); op(1, 8'hCC, 0, 0, 1, 0, 0, 8'h34, "R9"); wr(12, "R9"); rdat("R9"); clr();

    op(0, 0, 1, 1, 1, 0, 0, 8'hEE, "R10"); op(0, 0, 0, 1, 1, 0, 0, 8'hEE, "R10");
    op(0, 0, 0, 0, 0, 1, 1, 8'hE1, "R10"); idle("R10");

    @(negedge clk); rst_n = 1'b0;
    for (int i = 0; i < N; i++) mreg[i] = 0;
    midx = 0; mphase = 0;
    @(negedge clk); rst_n = 1'b1;
    ridx("R1"); wr(11, "R1"); rdat("R1");

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: done=0 expected=1");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule